// File: doc/BRIEF.md
# Streaming Adler-32 Checksum Engine

This block computes an Adler-32 checksum over a byte stream, one byte per clock in which the byte qualifier is high. A start strobe resets the two running sums, and an end strobe closes the message. One cycle after the end strobe the block raises a single-cycle done pulse and presents the 32-bit checksum. The checksum then stays fixed until the next start. It is intended for links where a cheap, fast integrity check is more useful than the stronger detection of a CRC.

Two 16-bit sums are kept, each below the prime 65521. The low sum adds every accepted byte. The high sum adds the updated low sum after every byte. The checksum is the high sum in the upper half and the low sum in the lower half. The caller can supply an expected checksum with an enable. The block then reports, together with done, whether the result agrees with it.

Top module: `adler32_stream`

## Requirements
- R1: Reset and the start strobe both set the low sum to 1 and the high sum to 0. A byte presented in the same cycle as the start strobe is accumulated onto these fresh values, and any partial message in progress is discarded.
- R2: Each accepted byte updates the low sum to (low + byte) mod 65521. The stored low sum is always below 65521.
- R3: Each accepted byte updates the high sum to (high + new low sum) mod 65521. The stored high sum is always below 65521.
- R4: `sum_out` carries the high sum in bits 31:16 and the low sum in bits 15:0.
- R5: `done` is high for exactly one cycle, in the cycle after the end strobe is taken. A byte presented together with the end strobe is included in the checksum.
- R6: An empty message, with start and end in the same cycle and no byte, yields 0x00000001.
- R7: After a message ends, bytes and end strobes are ignored until the next start strobe. The checksum holds and `done` stays low.
- R8: If `cmp_en` is high with the end strobe, `match` is high in the done cycle exactly when the final checksum equals `cmp_value`. Otherwise `match` stays low. `match` is never high without `done`.
- R9: Cycles with `in_valid` low leave both sums unchanged, so idle gaps inside a message do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sop | input | 1 | Start of message; clears the sums |
| in_valid | input | 1 | `in_byte` carries a byte this cycle |
| in_byte | input | 8 | Data byte |
| eop | input | 1 | End of message; closes after this cycle's byte |
| cmp_en | input | 1 | Compare the result against `cmp_value` |
| cmp_value | input | 32 | Expected checksum |
| sum_out | output | 32 | Checksum {high sum, low sum} |
| done | output | 1 | One-cycle pulse when the checksum is final |
| match | output | 1 | Checksum equals `cmp_value` (with `done`) |

## Verification
The bench applies every single-byte value and long runs of 0xFF. These long runs force both sums through many wraps of the modulus. A design that reduced modulo 65536, or that kept a sum equal to 65521 instead of folding it to 0, gives the wrong checksum there. Ramps and scrambled patterns with idle gaps expose a design that accumulates on idle cycles or adds the old low sum into the high sum. Empty messages, a restart in the middle of a message, and traffic after a message has ended catch a design that mis-initialises, keeps stale sums, or re-arms without a start. Correct, corrupted and disabled compare values catch a match flag that is inverted, ignores its enable, or is left asserted.

// File: rtl/adler32_stream.sv
module adler32_stream #(
  parameter int unsigned MODULUS = 65521,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned SUM_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sop,
  input  logic               in_valid,
  input  logic [BYTE_W-1:0]  in_byte,
  input  logic               eop,
  input  logic               cmp_en,
  input  logic [2*SUM_W-1:0] cmp_value,
  output logic [2*SUM_W-1:0] sum_out,
  output logic               done,
  output logic               match
);

  localparam int unsigned W = SUM_W + 1;
  localparam logic [W-1:0] MOD_W = W'(MODULUS);
  localparam logic [SUM_W-1:0] ONE = SUM_W'(1);

  logic [SUM_W-1:0] lo_q, hi_q;
  logic             open_q;

  logic             live, take, finish;
  logic [SUM_W-1:0] lo_base, hi_base, lo_new, hi_new;
  logic [W-1:0]     lo_raw, lo_red, hi_raw, hi_red;

  assign live    = open_q | sop;
  assign take    = live & in_valid;
  assign finish  = live & eop;
  assign lo_base = sop ? ONE : lo_q;
  assign hi_base = sop ? '0  : hi_q;

  assign lo_raw = {1'b0, lo_base} + {{(W-BYTE_W){1'b0}}, in_byte};
  assign lo_red = (lo_raw >= MOD_W) ? lo_raw - MOD_W : lo_raw;
  assign hi_raw = {1'b0, hi_base} + lo_red;
  assign hi_red = (hi_raw >= MOD_W) ? hi_raw - MOD_W : hi_raw;

  assign lo_new = take ? lo_red[SUM_W-1:0] : lo_base;
  assign hi_new = take ? hi_red[SUM_W-1:0] : hi_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q   <= ONE;
      hi_q   <= '0;
      open_q <= 1'b1;
      done   <= 1'b0;
      match  <= 1'b0;
    end else begin
      lo_q   <= lo_new;
      hi_q   <= hi_new;
      open_q <= finish ? 1'b0 : live;
      done   <= finish;
      match  <= finish & cmp_en & ({hi_new, lo_new} == cmp_value);
    end
  end

  assign sum_out = {hi_q, lo_q};

  a_r2_lo_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, lo_q} < MOD_W);
  a_r3_hi_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, hi_q} < MOD_W);
  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sop && !in_valid |=> sum_out == {{SUM_W{1'b0}}, ONE});
  a_r7_closed_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !open_q && !sop |=> $stable(sum_out) && !done);
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && !sop |=> $stable(sum_out));
  a_r8_match_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> done);
  a_r5_done_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(eop));

endmodule

// File: tb/adler32_stream_tb.sv
module adler32_stream_tb;
  localparam int MODV = 65521;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sop = 1'b0, in_valid = 1'b0, eop = 1'b0, cmp_en = 1'b0;
  logic [7:0]  in_byte = '0;
  logic [31:0] cmp_value = '0;
  logic [31:0] sum_out;
  logic        done, match;

  int vectors = 0;
  int misses  = 0;

  always #10 clk = ~clk;

  adler32_stream u_dut (
    .clk(clk), .rst_n(rst_n), .sop(sop), .in_valid(in_valid),
    .in_byte(in_byte), .eop(eop), .cmp_en(cmp_en), .cmp_value(cmp_value),
    .sum_out(sum_out), .done(done), .match(match)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input int kind, input int i, input int seed);
    case (kind)
      0:       return 8'(seed);
      1:       return 8'(i * seed + 7);
      default: return 8'((i * i * 31 + i * seed) ^ (i >> 3));
    endcase
  endfunction

  task automatic idle_inputs();
    sop = 0; in_valid = 0; eop = 0; cmp_en = 0; in_byte = '0;
  endtask

  // mode: 0 no compare, 1 correct compare, 2 corrupted compare, 3 correct value but disabled
  task automatic run_msg(input int len, input int kind, input int seed,
                         input bit gaps, input int mode, input string req);
    int s1 = 1;
    int s2 = 0;
    logic [31:0] expv;
    for (int i = 0; i < len; i++) begin
      s1 = (s1 + int'(gen(kind, i, seed))) % MODV;
      s2 = (s2 + s1) % MODV;
    end
    expv = {16'(s2), 16'(s1)};
    if (len == 0) begin
      @(negedge clk);
      sop = 1; eop = 1; in_valid = 0;
      cmp_en = (mode == 1 || mode == 2);
      cmp_value = (mode == 2) ? expv ^ 32'h0001_0000 : expv;
    end
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk);
        idle_inputs();
        in_byte = 8'hA5;
      end
      @(negedge clk);
      sop = (i == 0); in_valid = 1; in_byte = gen(kind, i, seed);
      eop = (i == len - 1);
      cmp_en = eop && (mode == 1 || mode == 2);
      cmp_value = (mode == 2) ? expv ^ 32'h0000_0001 : expv;
    end
    @(negedge clk);
    idle_inputs();
    chk(done === 1'b1, {req, " R5 done"}, {31'd0, done}, 32'd1);
    chk(sum_out === expv, {req, " R4 checksum"}, sum_out, expv);
    chk(match === (mode == 1), {req, " R8 match"}, {31'd0, match}, {31'd0, mode == 1});
    @(negedge clk);
    chk(done === 1'b0, {req, " R5 single pulse"}, {31'd0, done}, 32'd0);
    chk(sum_out === expv, {req, " R7 hold"}, sum_out, expv);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sum_out === 32'h1, "R1 reset value", sum_out, 32'h1);
    chk(done === 1'b0 && match === 1'b0, "R1 reset flags", {30'd0, done, match}, 32'd0);

    run_msg(0, 0, 0, 0, 1, "R6 empty");
    run_msg(0, 0, 0, 0, 2, "R6 empty bad cmp");

    for (int b = 0; b < 256; b++) run_msg(1, 0, b, 0, 0, "R2 single byte");

    run_msg(1000, 0, 255, 0, 1, "R2 R3 ff run");
    run_msg(4000, 0, 255, 0, 0, "R2 R3 long ff run");
    run_msg(600, 1, 13, 1, 1, "R9 ramp gaps");
    run_msg(777, 2, 91, 1, 2, "R9 scramble gaps bad cmp");
    run_msg(513, 2, 5, 0, 3, "R8 cmp disabled");
    for (int n = 2; n < 40; n++) run_msg(n, 2, n * 7, n[0], 1, "R3 short mix");

    // R1: restart in the middle of a message
    @(negedge clk);
    sop = 1; in_valid = 1; in_byte = 8'h77;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      sop = 0; in_valid = 1; in_byte = 8'(8'hF0 + i);
    end
    run_msg(9, 1, 3, 0, 1, "R1 restart");

    // R7: traffic after the end is ignored
    held = sum_out;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      sop = 0; in_valid = 1; in_byte = 8'(i * 17); eop = (i % 5 == 4);
      cmp_en = 1; cmp_value = held;
      @(negedge clk);
      idle_inputs();
      chk(sum_out === held, "R7 ignored bytes", sum_out, held);
      chk(done === 1'b0 && match === 1'b0, "R7 no done", {30'd0, done, match}, 32'd0);
    end

    run_msg(300, 1, 1, 0, 1, "R1 after closed");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule